// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit

This unit gathers the interrupt events of a network controller into one level interrupt line. The events are receive-queue done, transmit-queue done and link status change. Each event pulse sets a sticky cause bit. Software can also raise cause bits by writing a dedicated cause-set register.

The mask cannot be written directly. One register offset only turns mask bits on, and another only turns them off. Writing all ones to the mask-clear offset silences every source at once. The interrupt line is high while any cause bit is both pending and enabled, with one register stage on the way. Reading the cause register returns the pending bits and clears exactly those bits.

A handler can loop on a read of the cause register until the pending-and-enabled set is empty. An event that lands in the same clock as the read is not lost. It shows up on the next read.

Top module: `intr_cause_unit`

## Requirements
- R1: After reset, the cause register and the mask register both read 0 and `irqOut` is low.
- R2: A one-cycle pulse on `evtRxDone`, `evtTxDone` or `evtLinkChg` sets cause bit 0, bit 1 or bit 20 respectively. The bit is set after the clock edge that samples the pulse, and it stays set until a cause read clears it.
- R3: A read at byte offset 0x800 presents the pending cause bits on `regRdata` after the clock edge that samples `regRd`, and clears those bits at that same edge. An immediate second read returns 0.
- R4: An event sampled at the same edge as a cause read is not part of the returned value, and it remains pending for the next read.
- R5: A write at offset 0x808 sets every implemented cause bit (0, 1, 20) whose data bit is 1. Other cause bits stay unchanged.
- R6: A write at offset 0x880 sets each implemented mask bit whose data bit is 1. Data bits of 0 leave the mask unchanged. A read at 0x880 returns the current mask.
- R7: A write at offset 0x888 clears each mask bit whose data bit is 1. Writing all ones clears the whole mask.
- R8: `irqOut` equals the OR of (cause AND mask), delayed by one register. It rises two edges after an enabled event is sampled, and falls two edges after the cause read that empties it.
- R9: Cause and mask bits other than 0, 1 and 20 always read 0. A write at offset 0x800 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtRxDone | input | 1 | Receive-queue event pulse |
| evtTxDone | input | 1 | Transmit-queue event pulse |
| evtLinkChg | input | 1 | Link status change pulse |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, valid after the edge that samples `regRd` |
| irqOut | output | 1 | Level interrupt request |

## Verification
The read-to-clear of the cause register and the arrival of a hardware event can fall in the same clock. That is the point where a careless clear would drop an event. The bench first leaves a transmit event pending. It then raises the receive event in the very cycle it issues a cause read. It expects the read to return only the transmit bit and the next read to return only the receive bit. The scoreboard holds every expected read value, so a lost or early-reported event shows up as a mismatch at the exact read where it happened.

// File: rtl/intr_cause_pkg.sv
package intr_cause_pkg;
  localparam int CAUSE_OFF    = 'h800;
  localparam int CAUSESET_OFF = 'h808;
  localparam int MASKSET_OFF  = 'h880;
  localparam int MASKCLR_OFF  = 'h888;

  typedef struct packed {
    logic rdCause;
    logic rdMask;
    logic wrCauseSet;
    logic wrMaskSet;
    logic wrMaskClr;
  } strobe_t;
endpackage

// File: rtl/intr_cause_ctrl.sv
module intr_cause_ctrl
  import intr_cause_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb
);
  logic hitCause, hitCauseSet, hitMaskSet, hitMaskClr;

  assign hitCause    = (regAddr == ADDR_W'(CAUSE_OFF));
  assign hitCauseSet = (regAddr == ADDR_W'(CAUSESET_OFF));
  assign hitMaskSet  = (regAddr == ADDR_W'(MASKSET_OFF));
  assign hitMaskClr  = (regAddr == ADDR_W'(MASKCLR_OFF));

  // A write wins when both strobes are raised together.
  always_comb begin
    strb            = '0;
    strb.rdCause    = regRd && !regWr && hitCause;
    strb.rdMask     = regRd && !regWr && hitMaskSet;
    strb.wrCauseSet = regWr && hitCauseSet;
    strb.wrMaskSet  = regWr && hitMaskSet;
    strb.wrMaskClr  = regWr && hitMaskClr;
  end

  // At most one strobe per cycle (supports R3, R6, R7)
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));
endmodule

// File: rtl/intr_cause_dp.sv
module intr_cause_dp
  import intr_cause_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RX_BIT   = 0,
  parameter int TX_BIT   = 1,
  parameter int LINK_BIT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evtRxDone,
  input  logic              evtTxDone,
  input  logic              evtLinkChg,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);
  localparam logic [DATA_W-1:0] ONE = 1;
  localparam logic [DATA_W-1:0] IMPL_MASK =
    (ONE << RX_BIT) | (ONE << TX_BIT) | (ONE << LINK_BIT);

  logic [DATA_W-1:0] cause, mask, causeNxt, maskNxt;
  logic [DATA_W-1:0] evtVec, clrVec, setVec;

  always_comb begin
    evtVec           = '0;
    evtVec[RX_BIT]   = evtRxDone;
    evtVec[TX_BIT]   = evtTxDone;
    evtVec[LINK_BIT] = evtLinkChg;
    clrVec   = strb.rdCause    ? cause : '0;
    setVec   = strb.wrCauseSet ? (regWdata & IMPL_MASK) : '0;
    causeNxt = (cause & ~clrVec) | evtVec | setVec;
    maskNxt  = mask;
    if (strb.wrMaskSet) maskNxt = maskNxt | (regWdata & IMPL_MASK);
    if (strb.wrMaskClr) maskNxt = maskNxt & ~regWdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause    <= '0;
      mask     <= '0;
      regRdata <= '0;
      irqOut   <= 1'b0;
    end else begin
      cause  <= causeNxt;
      mask   <= maskNxt;
      irqOut <= |(cause & mask);
      if (strb.rdCause)     regRdata <= cause;
      else if (strb.rdMask) regRdata <= mask;
    end
  end

  assert_rx_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evtRxDone |=> cause[RX_BIT]);
  assert_link_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evtLinkChg |=> cause[LINK_BIT]);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rdCause |=> ((cause & $past(cause)) == $past(cause)));
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdCause && !strb.wrCauseSet) |=>
      ((cause & $past(cause) & ~$past(evtVec)) == '0));
  assert_event_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdCause && evtTxDone) |=> cause[TX_BIT]);
  assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrMaskSet |=> ((mask & $past(regWdata) & IMPL_MASK) ==
                        ($past(regWdata) & IMPL_MASK)));
  assert_mask_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrMaskClr |=> ((mask & $past(regWdata)) == '0));
  assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irqOut == $past(|(cause & mask))));
endmodule

// File: rtl/intr_cause_unit.sv
module intr_cause_unit
  import intr_cause_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int RX_BIT   = 0,
  parameter int TX_BIT   = 1,
  parameter int LINK_BIT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evtRxDone,
  input  logic              evtTxDone,
  input  logic              evtLinkChg,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);
  strobe_t strb;

  intr_cause_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .regRd(regRd), .regWr(regWr),
    .regAddr(regAddr), .strb(strb)
  );

  intr_cause_dp #(
    .DATA_W(DATA_W), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT), .LINK_BIT(LINK_BIT)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .evtRxDone(evtRxDone), .evtTxDone(evtTxDone),
    .evtLinkChg(evtLinkChg), .strb(strb), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/intr_cause_unit_tb_top.sv
module intr_cause_unit_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_CAUSE = 16'h0800;
  localparam logic [AW-1:0] A_CSET  = 16'h0808;
  localparam logic [AW-1:0] A_MSET  = 16'h0880;
  localparam logic [AW-1:0] A_MCLR  = 16'h0888;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evtRxDone = 1'b0, evtTxDone = 1'b0, evtLinkChg = 1'b0;
  logic regRd = 1'b0, regWr = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  logic irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;
  logic rdIssuedQ = 1'b0;

  logic [DW-1:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  intr_cause_unit dut_i (
    .clk(clk), .rst_n(rst_n), .evtRxDone(evtRxDone), .evtTxDone(evtTxDone),
    .evtLinkChg(evtLinkChg), .regRd(regRd), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  always @(posedge clk) rdIssuedQ <= regRd;

  // Monitor: read data is valid after the edge that sampled regRd
  always @(negedge clk) begin
    if (rdIssuedQ && expQ.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (regRdata !== e) begin
        nFails++;
        $display("FAIL %s: read got %h expected %h", t, regRdata, e);
      end
    end
  end

  task automatic readReg(input logic [AW-1:0] a, input logic [DW-1:0] e,
                         input string t);
    regRd = 1'b1; regAddr = a;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic writeReg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic pulse(input bit rx, input bit tx, input bit lk);
    evtRxDone = rx; evtTxDone = tx; evtLinkChg = lk;
    @(negedge clk);
    evtRxDone = 1'b0; evtTxDone = 1'b0; evtLinkChg = 1'b0;
  endtask

  task automatic checkIrq(input logic e, input string t);
    nChecks++;
    if (irqOut !== e) begin
      nFails++;
      $display("FAIL %s: irqOut got %b expected %b", t, irqOut, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkIrq(1'b0, "R1");
    readReg(A_CAUSE, 32'h0, "R1 cause");
    readReg(A_MSET, 32'h0, "R1 mask");

    pulse(1, 0, 0);
    readReg(A_CAUSE, 32'h1, "R2 rx");
    readReg(A_CAUSE, 32'h0, "R3 cleared");
    pulse(0, 1, 1);
    @(negedge clk);
    readReg(A_CAUSE, 32'h0010_0002, "R2 tx+link");
    readReg(A_CAUSE, 32'h0, "R3 cleared");

    // Same-cycle event and read-to-clear
    pulse(0, 1, 0);
    evtRxDone = 1'b1;
    readReg(A_CAUSE, 32'h2, "R4 read during event");
    evtRxDone = 1'b0;
    readReg(A_CAUSE, 32'h1, "R4 event kept");
    readReg(A_CAUSE, 32'h0, "R3 cleared");

    writeReg(A_CSET, 32'hFFFF_FFFF);
    readReg(A_CAUSE, 32'h0010_0003, "R5 forced, R9 unimpl zero");
    writeReg(A_CSET, 32'h0000_0002);
    readReg(A_CAUSE, 32'h2, "R5 single bit");

    writeReg(A_MSET, 32'h1);
    readReg(A_MSET, 32'h1, "R6 set bit0");
    writeReg(A_MSET, 32'h0010_0000);
    readReg(A_MSET, 32'h0010_0001, "R6 zeros keep");
    writeReg(A_MSET, 32'hFFFF_FFFF);
    readReg(A_MSET, 32'h0010_0003, "R9 mask unimpl zero");
    writeReg(A_MCLR, 32'h2);
    readReg(A_MSET, 32'h0010_0001, "R7 clear one");
    writeReg(A_MCLR, 32'hFFFF_FFFF);
    readReg(A_MSET, 32'h0, "R7 clear all");

    // Interrupt level timing
    writeReg(A_MSET, 32'h1);
    pulse(0, 1, 0);
    repeat (2) @(negedge clk);
    checkIrq(1'b0, "R8 masked source");
    evtRxDone = 1'b1;
    @(negedge clk);
    evtRxDone = 1'b0;
    checkIrq(1'b0, "R8 one edge after event");
    @(negedge clk);
    checkIrq(1'b1, "R8 two edges after event");
    readReg(A_CAUSE, 32'h3, "R8 read pending");
    checkIrq(1'b1, "R8 still high one edge after read");
    @(negedge clk);
    checkIrq(1'b0, "R8 low two edges after read");

    // Writes to the cause offset do nothing
    pulse(1, 0, 0);
    writeReg(A_CAUSE, 32'hFFFF_FFFF);
    readReg(A_CAUSE, 32'h1, "R9 cause write ignored");
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule